// File: doc/BRIEF.md
# Video PLL Coast Window Generator

This block drives the coast request of a line-locked clock generator. While coast is high the generator holds its frequency and ignores horizontal sync. It is needed because horizontal sync edges go missing or become irregular around the vertical sync interval. The block takes horizontal sync, vertical sync and an external coast pin, plus static control inputs. It produces one active-high coast output and one detected-polarity status bit.

There are two sources. In pin mode the external coast pin is passed through after polarity correction. The polarity is either forced by control inputs or taken from a detector that watches the pin. The detector treats the level the pin holds most of the time as its idle level. In vertical-sync mode the block counts horizontal leading edges between successive vertical leading edges to learn the frame length in lines. Coast then opens a programmed number of lines before the predicted vertical edge. It closes a programmed number of lines after the real one.

The control values come from a register file that is held outside this block.

Top module: `coast_window_gen`

## Requirements
- R1: With `coast_src_vs` = 0 the coast output is derived only from the external pin. With `coast_src_vs` = 1 it is derived only from the sync timing, so the pin has no effect on it.
- R2: In pin mode with `pol_override` = 1, `pol_forced_high` = 1 passes the pin unchanged and `pol_forced_high` = 0 passes it inverted.
- R3: `pol_detected_o` resets to 1. At the last cycle of each window of 2^WIN_LOG clocks it becomes 0 if the pin was high on more than half the window's cycles, and 1 otherwise. It changes at no other time.
- R4: In pin mode with `pol_override` = 0, the detected polarity is used (1 = pin unchanged, 0 = inverted) and `pol_forced_high` has no effect.
- R5: The predicted frame length equals the number of horizontal leading edges seen between the two most recent vertical leading edges. A change in frame length moves the coast opening point one frame later.
- R6: Until two vertical leading edges have been seen, the pre-count is ignored. No coast appears before the first vertical edge.
- R7: In vertical-sync mode, once a frame has been measured with pre-count P > 0, coast rises in the cycle after the horizontal leading edge that brings the in-frame line count to (predicted length − P).
- R8: With post-count Q > 0, coast is high in the cycle after a vertical leading edge. It falls in the cycle after the Q-th following horizontal leading edge unless the pre window holds it.
- R9: With P = 0 and Q = 0 in vertical-sync mode, coast stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; sync inputs are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Horizontal sync, leading edge rising by default |
| vsync_i | input | 1 | Vertical sync, leading edge rising by default |
| coast_pin_i | input | 1 | External coast pin |
| coast_src_vs | input | 1 | Source select: 0 pin, 1 vertical-sync timing |
| pre_lines | input | CNT_W | Lines of coast before the predicted vertical edge |
| post_lines | input | CNT_W | Lines of coast after the vertical edge |
| pol_override | input | 1 | 1 forces pin polarity from `pol_forced_high` |
| pol_forced_high | input | 1 | Forced pin polarity: 1 active high, 0 active low |
| coast_o | output | 1 | Active-high coast request to the clock generator |
| pol_detected_o | output | 1 | Detected pin polarity: 1 active high, 0 active low |

## Verification
Several checks run on every cycle. Forced-polarity pin mode must be an exact or inverted copy of the pin. Coast must stay low in vertical-sync mode before any vertical edge. A non-zero post-count must give coast in the cycle after every vertical edge. The detected polarity may move only on the last cycle of a window. The line-by-line position of the coast opening and the close after Q lines can only be shown by the bench's frame scenarios, which track prediction across a change in frame length. The same holds for the majority decision of the detector.

// File: rtl/coast_pkg.sv
package coast_pkg;
   typedef enum logic {
      SRC_PIN   = 1'b0,
      SRC_VSYNC = 1'b1
   } coast_src_e;
endpackage

// File: rtl/cw_edge.sv
module cw_edge #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic lead_o
);
   localparam bit IDLE = ~RISING;
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE;
      else        prev_q <= sig_i;
   end

   generate
      if (RISING) begin : g_rise
         assign lead_o = sig_i & ~prev_q;
      end else begin : g_fall
         assign lead_o = ~sig_i & prev_q;
      end
   endgenerate
endmodule

// File: rtl/cw_line_predict.sv
module cw_line_predict #(
   parameter int LINE_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hs_lead,
   input  logic              vs_lead,
   output logic [LINE_W-1:0] line_cnt,
   output logic [LINE_W-1:0] frame_len,
   output logic              valid
);
   localparam logic [LINE_W-1:0] LMAX = '1;
   logic              seen_q;
   logic [LINE_W-1:0] cnt_inc;

   // saturating increment on a horizontal leading edge
   assign cnt_inc = (hs_lead && line_cnt != LMAX) ? line_cnt + LINE_W'(1) : line_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_cnt  <= '0;
         frame_len <= '0;
         seen_q    <= 1'b0;
         valid     <= 1'b0;
      end else if (vs_lead) begin
         frame_len <= cnt_inc;
         line_cnt  <= '0;
         seen_q    <= 1'b1;
         valid     <= valid | seen_q;
      end else begin
         line_cnt  <= cnt_inc;
      end
   end
endmodule

// File: rtl/cw_window.sv
module cw_window #(
   parameter int CNT_W  = 8,
   parameter int LINE_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hs_lead,
   input  logic              vs_lead,
   input  logic [LINE_W-1:0] line_cnt,
   input  logic [LINE_W-1:0] frame_len,
   input  logic              valid,
   input  logic [CNT_W-1:0]  pre,
   input  logic [CNT_W-1:0]  post,
   output logic              win_o
);
   logic [LINE_W:0]  reach;
   logic             pre_on;
   logic             post_on;
   logic [CNT_W-1:0] left_q;

   assign reach  = {1'b0, line_cnt} + (LINE_W+1)'(pre);
   assign pre_on = valid && (pre != '0) && (reach >= {1'b0, frame_len});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         post_on <= 1'b0;
         left_q  <= '0;
      end else if (vs_lead) begin
         post_on <= (post != '0);
         left_q  <= post;
      end else if (hs_lead && post_on) begin
         left_q <= left_q - CNT_W'(1);
         if (left_q == CNT_W'(1)) post_on <= 1'b0;
      end
   end

   assign win_o = pre_on | post_on;
endmodule

// File: rtl/cw_pol_detect.sv
module cw_pol_detect #(
   parameter int WIN_LOG = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic active_high_o,
   output logic win_last_o
);
   localparam int              WIN  = 1 << WIN_LOG;
   localparam logic [WIN_LOG:0] HALF = (WIN_LOG+1)'(WIN / 2);

   logic [WIN_LOG-1:0] win_cnt;
   logic [WIN_LOG:0]   hi_cnt;
   logic [WIN_LOG:0]   total;

   assign win_last_o = &win_cnt;
   assign total      = hi_cnt + (WIN_LOG+1)'(pin_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt       <= '0;
         hi_cnt        <= '0;
         active_high_o <= 1'b1;
      end else begin
         win_cnt <= win_cnt + WIN_LOG'(1);
         if (win_last_o) begin
            hi_cnt        <= '0;
            active_high_o <= !(total > HALF);
         end else begin
            hi_cnt <= total;
         end
      end
   end
endmodule

// File: rtl/coast_window_gen.sv
module coast_window_gen #(
   parameter int CNT_W          = 8,
   parameter int LINE_W         = 11,
   parameter int WIN_LOG        = 8,
   parameter bit HS_LEAD_RISING = 1'b1,
   parameter bit VS_LEAD_RISING = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hsync_i,
   input  logic             vsync_i,
   input  logic             coast_pin_i,
   input  logic             coast_src_vs,
   input  logic [CNT_W-1:0] pre_lines,
   input  logic [CNT_W-1:0] post_lines,
   input  logic             pol_override,
   input  logic             pol_forced_high,
   output logic             coast_o,
   output logic             pol_detected_o
);
   import coast_pkg::*;

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
      if (LINE_W < CNT_W) begin : g_bad_line
         $error("LINE_W must not be narrower than CNT_W");
      end
      if (WIN_LOG < 2 || WIN_LOG > 24) begin : g_bad_win
         $error("WIN_LOG out of range 2..24");
      end
   endgenerate

   coast_src_e        src;
   logic              hs_lead, vs_lead;
   logic [LINE_W-1:0] line_cnt, frame_len;
   logic              meas_valid;
   logic              vs_win;
   logic              pol_eff, pin_coast;
   logic              win_last;

   assign src = coast_src_e'(coast_src_vs);

   cw_edge #(.RISING(HS_LEAD_RISING)) u_hs_edge (
      .clk(clk), .rst_n(rst_n), .sig_i(hsync_i), .lead_o(hs_lead));

   cw_edge #(.RISING(VS_LEAD_RISING)) u_vs_edge (
      .clk(clk), .rst_n(rst_n), .sig_i(vsync_i), .lead_o(vs_lead));

   cw_line_predict #(.LINE_W(LINE_W)) u_pred (
      .clk(clk), .rst_n(rst_n), .hs_lead(hs_lead), .vs_lead(vs_lead),
      .line_cnt(line_cnt), .frame_len(frame_len), .valid(meas_valid));

   cw_window #(.CNT_W(CNT_W), .LINE_W(LINE_W)) u_win (
      .clk(clk), .rst_n(rst_n), .hs_lead(hs_lead), .vs_lead(vs_lead),
      .line_cnt(line_cnt), .frame_len(frame_len), .valid(meas_valid),
      .pre(pre_lines), .post(post_lines), .win_o(vs_win));

   cw_pol_detect #(.WIN_LOG(WIN_LOG)) u_pol (
      .clk(clk), .rst_n(rst_n), .pin_i(coast_pin_i),
      .active_high_o(pol_detected_o), .win_last_o(win_last));

   assign pol_eff   = pol_override ? pol_forced_high : pol_detected_o;
   assign pin_coast = pol_eff ? coast_pin_i : ~coast_pin_i;
   assign coast_o   = (src == SRC_VSYNC) ? vs_win : pin_coast;
endmodule

// File: rtl/coast_window_chk.sv
module coast_window_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             vsync_i,
   input logic             coast_pin_i,
   input logic             coast_src_vs,
   input logic [CNT_W-1:0] post_lines,
   input logic             pol_override,
   input logic             pol_forced_high,
   input logic             coast_o,
   input logic             pol_detected_o,
   input logic             win_last
);
   logic       vs_prev;
   logic       vs_rise;
   logic [1:0] vs_seen;

   assign vs_rise = vsync_i & ~vs_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vs_prev <= 1'b0;
         vs_seen <= '0;
      end else begin
         vs_prev <= vsync_i;
         if (vs_rise && vs_seen != 2'd3) vs_seen <= vs_seen + 2'd1;
      end
   end

   // R1: a pin toggle under steady pin-mode controls toggles the output
   a_r1_pin_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (!coast_src_vs && $past(!coast_src_vs) && !$stable(coast_pin_i) &&
       $stable(pol_detected_o) && $stable(pol_override) && $stable(pol_forced_high))
      |-> !$stable(coast_o));

   // R2: forced polarity gives a straight or inverted copy of the pin
   a_r2_forced_pol: assert property (@(posedge clk) disable iff (!rst_n)
      (!coast_src_vs && pol_override) |-> (coast_o == (pol_forced_high ? coast_pin_i : !coast_pin_i)));

   // R3: the detected polarity moves only at a window boundary
   a_r3_det_window: assert property (@(posedge clk) disable iff (!rst_n)
      !win_last |=> $stable(pol_detected_o));

   // R6: no coast in vertical-sync mode before any vertical edge
   a_r6_no_early: assert property (@(posedge clk) disable iff (!rst_n)
      (coast_src_vs && vs_seen == 2'd0) |-> !coast_o);

   // R8: a non-zero post-count opens coast right after a vertical edge
   a_r8_post_open: assert property (@(posedge clk) disable iff (!rst_n)
      (coast_src_vs && vs_rise && post_lines != '0) |=> coast_o);
endmodule

bind coast_window_gen coast_window_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .coast_pin_i(coast_pin_i),
   .coast_src_vs(coast_src_vs), .post_lines(post_lines),
   .pol_override(pol_override), .pol_forced_high(pol_forced_high),
   .coast_o(coast_o), .pol_detected_o(pol_detected_o),
   .win_last(u_pol.win_last_o));

// File: tb/sim_coast_window_gen.sv
module sim_coast_window_gen;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n, hsync_i, vsync_i, coast_pin_i, coast_src_vs;
   logic [7:0] pre_lines, post_lines;
   logic       pol_override, pol_forced_high;
   logic       coast_o, pol_detected_o;

   coast_window_gen u0 (
      .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .vsync_i(vsync_i),
      .coast_pin_i(coast_pin_i), .coast_src_vs(coast_src_vs),
      .pre_lines(pre_lines), .post_lines(post_lines),
      .pol_override(pol_override), .pol_forced_high(pol_forced_high),
      .coast_o(coast_o), .pol_detected_o(pol_detected_o));

   int n_chk  = 0;
   int n_fail = 0;

   // model of the frame measurement, kept from the stimulus only
   bit m_seen  = 1'b0;
   bit m_valid = 1'b0;
   int m_len   = 0;
   int m_prev  = 0;

   // {src, override, forced_high, pin, expected coast}
   localparam logic [4:0] VEC [8] = '{
      5'b0_1_1_1_1, 5'b0_1_1_0_0, 5'b0_1_0_1_0, 5'b0_1_0_0_1,
      5'b0_0_1_1_1, 5'b0_0_0_0_0, 5'b1_1_0_1_0, 5'b1_0_1_1_0
   };

   task automatic check(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic frame(input int n, input int p, input int q);
      bit    exp;
      string tag;
      vsync_i = 1'b1;
      @(negedge clk);
      if (m_seen) begin
         m_valid = 1'b1;
         m_len   = m_prev;
      end
      m_seen = 1'b1;
      exp = (q != 0) || (m_valid && p != 0 && p >= m_len);
      tag = (p == 0 && q == 0) ? "R9 no coast at vsync" :
            (q != 0) ? "R8 post opens at vsync" : "R6 vsync edge";
      check(tag, coast_o, exp);
      repeat (2) @(negedge clk);
      vsync_i = 1'b0;
      @(negedge clk);
      for (int k = 1; k <= n; k++) begin
         hsync_i = 1'b1;
         @(negedge clk);
         exp = (k < q) || (m_valid && p != 0 && k + p >= m_len);
         if (p == 0 && q == 0)      tag = "R9 line";
         else if (!m_valid)         tag = "R6 first frame line";
         else if (k <= q)           tag = "R8 post line";
         else if (n != m_len)       tag = "R5 new length line";
         else                       tag = "R7 pre line";
         check(tag, coast_o, exp);
         @(negedge clk);
         hsync_i = 1'b0;
         repeat (5) @(negedge clk);
      end
      m_prev = n;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0; hsync_i = 1'b0; vsync_i = 1'b0; coast_pin_i = 1'b0;
      coast_src_vs = 1'b0; pre_lines = '0; post_lines = '0;
      pol_override = 1'b0; pol_forced_high = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R3 reset detected polarity", pol_detected_o, 1'b1);
      check("R4 reset coast", coast_o, 1'b0);

      // vector table: source select and polarity paths
      for (int i = 0; i < 8; i++) begin
         {coast_src_vs, pol_override, pol_forced_high, coast_pin_i} = VEC[i][4:1];
         #1;
         check(i < 4 ? "R2 forced polarity" : (i < 6 ? "R4 detected polarity" : "R1 pin ignored in vsync mode"),
               coast_o, VEC[i][0]);
         @(negedge clk);
      end

      // detector: pin held high for more than two windows
      coast_src_vs = 1'b0; pol_override = 1'b1; pol_forced_high = 1'b1; coast_pin_i = 1'b1;
      repeat (600) @(negedge clk);
      check("R3 mostly high gives active low", pol_detected_o, 1'b0);
      check("R2 forced high passes pin", coast_o, 1'b1);
      pol_override = 1'b0;
      #1;
      check("R4 detected low inverts pin high", coast_o, 1'b0);
      coast_pin_i = 1'b0;
      #1;
      check("R4 detected low inverts pin low", coast_o, 1'b1);
      repeat (600) @(negedge clk);
      check("R3 mostly low gives active high", pol_detected_o, 1'b1);
      check("R4 detected high passes pin", coast_o, 1'b0);

      // vertical-sync mode frames
      coast_src_vs = 1'b1; pol_override = 1'b1; pol_forced_high = 1'b0;
      pre_lines = 8'd3; post_lines = 8'd2;
      @(negedge clk);
      check("R1 pin mode inactive in vsync mode", coast_o, 1'b0);
      frame(10, 3, 2);
      frame(10, 3, 2);
      frame(10, 3, 2);
      pre_lines = 8'd0; post_lines = 8'd0;
      frame(10, 0, 0);
      pre_lines = 8'd4; post_lines = 8'd1;
      frame(12, 4, 1);
      frame(12, 4, 1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule